// File: doc/BRIEF.md
# TLB Access Permission Checker

This block decides whether a single memory access may use a TLB entry that has already matched the virtual address. It takes the entry's attribute bits (address-space tag, global, kernel-only, writable, executable, valid), the processor state (current process ID, user-mode flag), the access kind, a set of protection-enable bits, the global and per-segment translation configuration words, and a vector base. One cycle after a request strobe it reports whether the access is permitted. If not, it gives an 8-bit fault vector equal to the vector base plus an offset that names the cause.

Only the highest-priority failing cause selects the offset. Translation can be switched off globally, or for the segment being accessed. In either case the access passes with a bypass indication and no check is made. A reported fault leaves a pending flag set until exception handling acknowledges it. A further fault that arrives while that flag is still set is not reported as a fault. Instead it raises a sticky unrecoverable-fault error, which only reset clears.

Top module: `tlb_perm_check`

## Requirements
- R1: Translation is on only when bit 2 or bit 3 of `gcfg` is set. With both bits clear, a request gets `rsp_permit`=1 and `rsp_bypass`=1 and no fault, whatever the entry bits are.
- R2: When bit number `seg` of `segcfg` is set, the access bypasses translation (`rsp_permit`=1, `rsp_bypass`=1, no fault). The bits for other segments have no effect.
- R3: An entry with `ent_global`=0 faults when `ent_asid` differs from the low 8 bits of `cur_pid`. The vector is `vec_base`+0. With `ent_global`=1 the tag is not compared.
- R4: When `en_kern`=1, `ent_kern`=1 and `user_mode`=1, the access faults with `vec_base`+2.
- R5: A write (`acc_type`=1) faults with `vec_base`+3 when `en_write`=1 and `ent_wr`=0.
- R6: An instruction fetch (`acc_type`=2) faults with `vec_base`+3 when `en_exec`=1 and `ent_exec`=0. Reads (`acc_type`=0) and the reserved code 3 are never subject to the write or execute checks.
- R7: When `en_valid`=1 and `ent_valid`=0, the access faults with `vec_base`+1.
- R8: When several causes fail at once, the vector comes from the first one in this order: tag mismatch, kernel, write, execute, valid.
- R9: `fault_pending` is set by any reported fault and cleared by `fault_ack`. A fault reported in the same cycle as `fault_ack` keeps it set.
- R10: A failing access while `fault_pending`=1 and `fault_ack`=0 gives `rsp_fault`=0 and `rsp_permit`=0, and sets `fatal_err`. `fatal_err` stays set until reset.
- R11: The responses are registered. A request on `req_valid` at one clock edge is answered in the cycle after it. Without a request, `rsp_valid`, `rsp_permit`, `rsp_fault`, `rsp_bypass` and `rsp_vec` are 0. Reset clears every output.
- R12: The fault vector is the sum of `vec_base` and the offset, taken modulo 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request strobe |
| acc_type | input | 2 | 0 read, 1 write, 2 fetch, 3 reserved (treated as read) |
| seg | input | 4 | Segment index of the access |
| ent_asid | input | 8 | Address-space tag of the entry |
| ent_global | input | 1 | Entry shared by all processes |
| ent_kern | input | 1 | Entry restricted to supervisor mode |
| ent_wr | input | 1 | Entry writable |
| ent_exec | input | 1 | Entry executable |
| ent_valid | input | 1 | Entry valid |
| cur_pid | input | 32 | Current process ID |
| user_mode | input | 1 | Processor in user mode |
| en_kern | input | 1 | Enable kernel-protection check |
| en_write | input | 1 | Enable write-protection check |
| en_exec | input | 1 | Enable execute-protection check |
| en_valid | input | 1 | Enable valid-bit check |
| gcfg | input | 32 | Global configuration word |
| segcfg | input | 16 | Per-segment bypass bits |
| vec_base | input | 8 | Fault vector base |
| fault_ack | input | 1 | Exception handling has taken the pending fault |
| rsp_valid | output | 1 | Response strobe |
| rsp_permit | output | 1 | Access allowed |
| rsp_fault | output | 1 | Fault reported |
| rsp_vec | output | 8 | Fault vector, 0 when no fault |
| rsp_bypass | output | 1 | Access passed untranslated |
| fault_pending | output | 1 | A reported fault awaits acknowledge |
| fatal_err | output | 1 | Sticky unrecoverable-fault error |

## Verification
The properties assume that `acc_type`, `vec_base` and the entry bits are stable in the cycle a request is taken. This matters because the vector checks compare a response against the previous cycle's base and access kind. The stimulus changes inputs only on the falling edge and holds them over the rising edge that samples them. It also tests recursion only with requests that actually fail, so a rise of the error flag always follows a pending fault. Acknowledge pulses are given both alone and in the same cycle as a new fault, and the bench's behavioural model treats the two cases differently.

// File: rtl/tlb_perm_pkg.sv
package tlb_perm_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_e;

    typedef enum logic [2:0] {
        CAUSE_NONE  = 3'd0,
        CAUSE_ASID  = 3'd1,
        CAUSE_KERN  = 3'd2,
        CAUSE_WRITE = 3'd3,
        CAUSE_EXEC  = 3'd4,
        CAUSE_VALID = 3'd5
    } cause_e;

    // number of checks, in priority order (index 0 wins)
    localparam int NUM_CHECKS = 5;

    typedef struct packed {
        logic glob;
        logic kern;
        logic wr;
        logic ex;
        logic vld;
    } ent_flags_t;

    typedef struct packed {
        logic kern_en;
        logic wr_en;
        logic ex_en;
        logic vld_en;
    } prot_en_t;

    // priority slot -> cause
    function automatic cause_e cause_at(input int idx);
        case (idx)
            0:       return CAUSE_ASID;
            1:       return CAUSE_KERN;
            2:       return CAUSE_WRITE;
            3:       return CAUSE_EXEC;
            4:       return CAUSE_VALID;
            default: return CAUSE_NONE;
        endcase
    endfunction

    // cause -> offset from the vector base
    function automatic logic [1:0] cause_offset(input cause_e c);
        case (c)
            CAUSE_KERN:  return 2'd2;
            CAUSE_WRITE: return 2'd3;
            CAUSE_EXEC:  return 2'd3;
            CAUSE_VALID: return 2'd1;
            default:     return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/tlb_xlate_gate.sv
module tlb_xlate_gate #(
    parameter int GCFG_W = 32,
    parameter int EN_LO  = 2,
    parameter int EN_HI  = 3,
    parameter int SEG_W  = 4,
    localparam int NSEG  = 1 << SEG_W,
    localparam int EN_N  = EN_HI - EN_LO + 1
) (
    input  logic [GCFG_W-1:0] gcfg,
    input  logic [NSEG-1:0]   segcfg,
    input  logic [SEG_W-1:0]  seg,
    output logic              bypass
);
    logic [EN_N-1:0] en_bits;
    logic            xlate_on;
    logic            seg_flat;

    for (genvar g = 0; g < EN_N; g++) begin : g_en
        assign en_bits[g] = gcfg[EN_LO + g];
    end

    assign xlate_on = |en_bits;
    assign seg_flat = segcfg[seg];
    assign bypass   = ~xlate_on | seg_flat;
endmodule

// File: rtl/tlb_fault_prio.sv
module tlb_fault_prio
    import tlb_perm_pkg::*;
#(
    parameter int ASID_W = 8,
    parameter int PID_W  = 32,
    parameter int VEC_W  = 8
) (
    input  acc_kind_e         acc,
    input  ent_flags_t        flags,
    input  prot_en_t          prot,
    input  logic [ASID_W-1:0] ent_asid,
    input  logic [PID_W-1:0]  cur_pid,
    input  logic              user_mode,
    input  logic [VEC_W-1:0]  vec_base,
    output logic              any_fail,
    output cause_e            cause,
    output logic [VEC_W-1:0]  vec
);
    logic [NUM_CHECKS-1:0] fail;
    logic [NUM_CHECKS-1:0] first;

    assign fail[0] = ~flags.glob & (ent_asid != cur_pid[ASID_W-1:0]);
    assign fail[1] = prot.kern_en & flags.kern & user_mode;
    assign fail[2] = (acc == ACC_WRITE) & prot.wr_en & ~flags.wr;
    assign fail[3] = (acc == ACC_EXEC) & prot.ex_en & ~flags.ex;
    assign fail[4] = prot.vld_en & ~flags.vld;

    // one-hot of the first failing slot
    for (genvar i = 0; i < NUM_CHECKS; i++) begin : g_first
        if (i == 0) begin : g_top
            assign first[i] = fail[i];
        end else begin : g_rest
            assign first[i] = fail[i] & ~(|fail[i-1:0]);
        end
    end

    always_comb begin
        cause = CAUSE_NONE;
        for (int i = 0; i < NUM_CHECKS; i++) begin
            if (first[i]) cause = cause_at(i);
        end
    end

    assign any_fail = |fail;
    assign vec      = vec_base + {{(VEC_W-2){1'b0}}, cause_offset(cause)};
endmodule

// File: rtl/tlb_fault_track.sv
module tlb_fault_track (
    input  logic clk,
    input  logic rst,
    input  logic fault_in,
    input  logic ack,
    output logic report,
    output logic recur,
    output logic pending,
    output logic fatal
);
    logic pending_q;
    logic fatal_q;

    assign recur  = fault_in & pending_q & ~ack;
    assign report = fault_in & ~recur;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending_q <= 1'b0;
            fatal_q   <= 1'b0;
        end else begin
            pending_q <= report | (pending_q & ~ack);
            fatal_q   <= fatal_q | recur;
        end
    end

    assign pending = pending_q;
    assign fatal   = fatal_q;
endmodule

// File: rtl/tlb_perm_check.sv
module tlb_perm_check
    import tlb_perm_pkg::*;
#(
    parameter int ASID_W = 8,
    parameter int PID_W  = 32,
    parameter int VEC_W  = 8,
    parameter int GCFG_W = 32,
    parameter int SEG_W  = 4,
    localparam int NSEG  = 1 << SEG_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [1:0]        acc_type,
    input  logic [SEG_W-1:0]  seg,
    input  logic [ASID_W-1:0] ent_asid,
    input  logic              ent_global,
    input  logic              ent_kern,
    input  logic              ent_wr,
    input  logic              ent_exec,
    input  logic              ent_valid,
    input  logic [PID_W-1:0]  cur_pid,
    input  logic              user_mode,
    input  logic              en_kern,
    input  logic              en_write,
    input  logic              en_exec,
    input  logic              en_valid,
    input  logic [GCFG_W-1:0] gcfg,
    input  logic [NSEG-1:0]   segcfg,
    input  logic [VEC_W-1:0]  vec_base,
    input  logic              fault_ack,
    output logic              rsp_valid,
    output logic              rsp_permit,
    output logic              rsp_fault,
    output logic [VEC_W-1:0]  rsp_vec,
    output logic              rsp_bypass,
    output logic              fault_pending,
    output logic              fatal_err
);
    acc_kind_e        acc;
    ent_flags_t       flags;
    prot_en_t         prot;
    logic             bypass;
    logic             any_fail;
    cause_e           cause;
    logic [VEC_W-1:0] vec;
    logic             raw_fault;
    logic             report;
    logic             recur;

    assign acc   = acc_kind_e'(acc_type);
    assign flags = '{glob: ent_global, kern: ent_kern, wr: ent_wr,
                     ex: ent_exec, vld: ent_valid};
    assign prot  = '{kern_en: en_kern, wr_en: en_write,
                     ex_en: en_exec, vld_en: en_valid};

    tlb_xlate_gate #(
        .GCFG_W (GCFG_W),
        .EN_LO  (2),
        .EN_HI  (3),
        .SEG_W  (SEG_W)
    ) i_gate (
        .gcfg   (gcfg),
        .segcfg (segcfg),
        .seg    (seg),
        .bypass (bypass)
    );

    tlb_fault_prio #(
        .ASID_W (ASID_W),
        .PID_W  (PID_W),
        .VEC_W  (VEC_W)
    ) i_prio (
        .acc       (acc),
        .flags     (flags),
        .prot      (prot),
        .ent_asid  (ent_asid),
        .cur_pid   (cur_pid),
        .user_mode (user_mode),
        .vec_base  (vec_base),
        .any_fail  (any_fail),
        .cause     (cause),
        .vec       (vec)
    );

    assign raw_fault = req_valid & ~bypass & any_fail;

    tlb_fault_track i_track (
        .clk      (clk),
        .rst      (rst),
        .fault_in (raw_fault),
        .ack      (fault_ack),
        .report   (report),
        .recur    (recur),
        .pending  (fault_pending),
        .fatal    (fatal_err)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid  <= 1'b0;
            rsp_permit <= 1'b0;
            rsp_fault  <= 1'b0;
            rsp_vec    <= '0;
            rsp_bypass <= 1'b0;
        end else begin
            rsp_valid  <= req_valid;
            rsp_permit <= req_valid & (bypass | ~any_fail);
            rsp_fault  <= report;
            rsp_vec    <= report ? vec : '0;
            rsp_bypass <= req_valid & bypass;
        end
    end
endmodule

// File: rtl/tlb_perm_check_sva.sv
module tlb_perm_check_sva #(
    parameter int VEC_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic [1:0]       acc_type,
    input logic [VEC_W-1:0] vec_base,
    input logic             fault_ack,
    input logic             rsp_valid,
    input logic             rsp_permit,
    input logic             rsp_fault,
    input logic [VEC_W-1:0] rsp_vec,
    input logic             rsp_bypass,
    input logic             fault_pending,
    input logic             fatal_err
);
    logic [VEC_W-1:0] wx_vec;
    assign wx_vec = vec_base + VEC_W'(3);

    assert_fatal_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        fatal_err |=> fatal_err);

    assert_fatal_cause_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(fatal_err) |-> $past(req_valid) && $past(fault_pending) && !$past(fault_ack));

    assert_permit_fault_excl_R11: assert property (@(posedge clk) disable iff (rst)
        rsp_permit |-> !rsp_fault);

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> (!rsp_permit && !rsp_fault && !rsp_bypass));

    assert_fault_sets_pending_R9: assert property (@(posedge clk) disable iff (rst)
        rsp_fault |-> fault_pending);

    assert_bypass_permits_R1: assert property (@(posedge clk) disable iff (rst)
        rsp_bypass |-> rsp_permit);

    assert_read_no_wx_R6: assert property (@(posedge clk) disable iff (rst)
        (rsp_fault && $past(acc_type) == 2'd0) |-> rsp_vec != $past(wx_vec));

    assert_offset_range_R12: assert property (@(posedge clk) disable iff (rst)
        rsp_fault |-> (VEC_W'(rsp_vec - $past(vec_base)) <= VEC_W'(3)));
endmodule

bind tlb_perm_check tlb_perm_check_sva #(.VEC_W(VEC_W)) i_sva (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .acc_type      (acc_type),
    .vec_base      (vec_base),
    .fault_ack     (fault_ack),
    .rsp_valid     (rsp_valid),
    .rsp_permit    (rsp_permit),
    .rsp_fault     (rsp_fault),
    .rsp_vec       (rsp_vec),
    .rsp_bypass    (rsp_bypass),
    .fault_pending (fault_pending),
    .fatal_err     (fatal_err)
);

// File: tb/test_tlb_perm_check.sv
module test_tlb_perm_check;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [1:0]  acc_type;
    logic [3:0]  seg;
    logic [7:0]  ent_asid;
    logic        ent_global, ent_kern, ent_wr, ent_exec, ent_valid;
    logic [31:0] cur_pid;
    logic        user_mode;
    logic        en_kern, en_write, en_exec, en_valid;
    logic [31:0] gcfg;
    logic [15:0] segcfg;
    logic [7:0]  vec_base;
    logic        fault_ack;
    logic        rsp_valid, rsp_permit, rsp_fault, rsp_bypass;
    logic [7:0]  rsp_vec;
    logic        fault_pending, fatal_err;

    int checks = 0;
    int errors = 0;
    int m_pend = 0;
    int m_fatal = 0;
    bit done = 0;

    always #5 clk = ~clk;

    tlb_perm_check i_tlb_perm_check (
        .clk(clk), .rst(rst), .req_valid(req_valid), .acc_type(acc_type), .seg(seg),
        .ent_asid(ent_asid), .ent_global(ent_global), .ent_kern(ent_kern),
        .ent_wr(ent_wr), .ent_exec(ent_exec), .ent_valid(ent_valid),
        .cur_pid(cur_pid), .user_mode(user_mode), .en_kern(en_kern),
        .en_write(en_write), .en_exec(en_exec), .en_valid(en_valid),
        .gcfg(gcfg), .segcfg(segcfg), .vec_base(vec_base), .fault_ack(fault_ack),
        .rsp_valid(rsp_valid), .rsp_permit(rsp_permit), .rsp_fault(rsp_fault),
        .rsp_vec(rsp_vec), .rsp_bypass(rsp_bypass),
        .fault_pending(fault_pending), .fatal_err(fatal_err)
    );

    task automatic good_access();
        req_valid = 1; acc_type = 0; seg = 0; ent_asid = 8'h05;
        ent_global = 0; ent_kern = 0; ent_wr = 1; ent_exec = 1; ent_valid = 1;
        cur_pid = 32'h0000_0105; user_mode = 1;
        en_kern = 1; en_write = 1; en_exec = 1; en_valid = 1;
        gcfg = 32'h4; segcfg = 16'h0; vec_base = 8'h40; fault_ack = 0;
    endtask

    task automatic compare(input string tag, input int ev, input int ep, input int ef,
                           input int evec, input int eb);
        int av = {rsp_valid, rsp_permit, rsp_fault, rsp_bypass, fault_pending, fatal_err};
        int xv = {ev[0], ep[0], ef[0], eb[0], m_pend[0], m_fatal[0]};
        checks++;
        if (av != xv || rsp_vec != evec[7:0]) begin
            errors++;
            $display("FAIL %s: got flags(v,p,f,b,pend,fatal)=%b vec=%h, expected %b vec=%h",
                     tag, av[5:0], rsp_vec, xv[5:0], evec[7:0]);
        end
    endtask

    // behavioural reference: compute response from current inputs, then clock
    task automatic tick(input string tag);
        int ev = 0, ep = 0, ef = 0, evec = 0, eb = 0, off = -1;
        bit byp;
        byp = (gcfg[2] == 0 && gcfg[3] == 0) || segcfg[seg];
        if (req_valid) begin
            ev = 1;
            if (byp) begin
                ep = 1; eb = 1;
            end else begin
                if (!ent_global && ent_asid != cur_pid[7:0]) off = 0;
                else if (en_kern && ent_kern && user_mode) off = 2;
                else if (acc_type == 1 && en_write && !ent_wr) off = 3;
                else if (acc_type == 2 && en_exec && !ent_exec) off = 3;
                else if (en_valid && !ent_valid) off = 1;
                if (off < 0) ep = 1;
                else if (m_pend != 0 && !fault_ack) m_fatal = 1;
                else begin
                    ef = 1; evec = (vec_base + off) % 256;
                end
            end
        end
        if (ef != 0) m_pend = 1;
        else if (fault_ack) m_pend = 0;
        @(posedge clk);
        #1;
        compare(tag, ev, ep, ef, evec, eb);
        @(negedge clk);
    endtask

    task automatic ack_only(input string tag);
        good_access(); req_valid = 0; fault_ack = 1;
        tick(tag);
        fault_ack = 0;
    endtask

    task automatic do_reset();
        rst = 1;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst = 0;
        m_pend = 0; m_fatal = 0;
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 20000) begin
                errors++;
                $display("FAIL watchdog: got no end, expected finish within 20000 cycles");
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        good_access(); req_valid = 0;
        do_reset();
        compare("R11 reset state", 0, 0, 0, 0, 0);
        tick("R11 idle no request");
        good_access(); tick("R11 plain read permitted");

        // R1 global enable
        good_access(); gcfg = 0; ent_asid = 8'h77; ent_valid = 0; tick("R1 translation off");
        good_access(); gcfg = 32'hFFFF_FFF3; ent_kern = 1; tick("R1 other gcfg bits ignored");
        good_access(); gcfg = 32'h8; tick("R1 bit3 alone enables");
        // R2 segment bypass
        good_access(); seg = 5; segcfg = 16'h0020; ent_asid = 8'h99; tick("R2 segment bypass");
        good_access(); seg = 5; segcfg = 16'hFFDF; tick("R2 other segment bits ignored");

        // R3 tag
        good_access(); ent_asid = 8'h06; tick("R3 tag mismatch");
        ack_only("R9 ack clears pending");
        good_access(); ent_asid = 8'h06; ent_global = 1; tick("R3 global skips tag");
        good_access(); cur_pid = 32'hABCD_0005; tick("R3 only low pid bits compared");

        // R4 kernel
        good_access(); ent_kern = 1; tick("R4 kernel page from user");
        ack_only("R9 ack");
        good_access(); ent_kern = 1; user_mode = 0; tick("R4 supervisor allowed");
        good_access(); ent_kern = 1; en_kern = 0; tick("R4 check disabled");

        // R5 write
        good_access(); acc_type = 1; ent_wr = 0; tick("R5 write protect");
        ack_only("R9 ack");
        good_access(); acc_type = 1; ent_wr = 0; en_write = 0; tick("R5 check disabled");
        good_access(); acc_type = 0; ent_wr = 0; tick("R6 read ignores write bit");

        // R6 exec
        good_access(); acc_type = 2; ent_exec = 0; tick("R6 exec protect");
        ack_only("R9 ack");
        good_access(); acc_type = 0; ent_exec = 0; tick("R6 read ignores exec bit");
        good_access(); acc_type = 3; ent_exec = 0; ent_wr = 0; tick("R6 reserved code exempt");
        good_access(); acc_type = 1; ent_exec = 0; tick("R6 write ignores exec bit");
        good_access(); acc_type = 2; ent_exec = 0; en_exec = 0; tick("R6 check disabled");

        // R7 valid
        good_access(); ent_valid = 0; tick("R7 invalid entry");
        ack_only("R9 ack");
        good_access(); ent_valid = 0; en_valid = 0; tick("R7 check disabled");

        // R8 priority
        good_access(); acc_type = 1; ent_asid = 8'h00; ent_kern = 1; ent_wr = 0; ent_valid = 0;
        tick("R8 all fail tag wins");
        ack_only("R9 ack");
        good_access(); acc_type = 1; ent_kern = 1; ent_wr = 0; ent_valid = 0;
        tick("R8 kernel over write");
        ack_only("R9 ack");
        good_access(); acc_type = 1; ent_wr = 0; ent_valid = 0; tick("R8 write over valid");
        ack_only("R9 ack");
        good_access(); acc_type = 2; ent_exec = 0; ent_valid = 0; tick("R8 exec over valid");
        ack_only("R9 ack");

        // R12 wrap
        good_access(); vec_base = 8'hFE; acc_type = 1; ent_wr = 0; tick("R12 vector wraps");

        // R9 pending behaviour
        good_access(); req_valid = 0; tick("R9 pending held without ack");
        good_access(); tick("R9 pass keeps pending");
        good_access(); ent_valid = 0; fault_ack = 1; tick("R9 fault with ack reported");
        ack_only("R9 ack");

        // R10 recursion
        good_access(); ent_kern = 1; tick("R10 first fault");
        good_access(); ent_asid = 8'h33; tick("R10 recursive fault");
        ack_only("R10 ack leaves fatal");
        good_access(); tick("R10 fatal sticky");
        good_access(); ent_valid = 0; tick("R10 fault after ack reported");
        ack_only("R10 ack");
        good_access(); req_valid = 0;
        do_reset();
        compare("R10 reset clears fatal", 0, 0, 0, 0, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule